// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of words by a fixed number of clock cycles. A chain of flip-flops would move every word one stage on each clock. This block writes each word once into a dual-port storage array and leaves it there. Two address counters step through the array together. The write counter stores the incoming word at one location. The read counter fetches, in the same cycle, the word stored one full lap earlier. Each word therefore emerges a fixed `DEPTH` cycles after it was presented.

The array is written so that an FPGA flow can map it to block RAM. For long delays this takes far less area than `DEPTH * WIDTH` flip-flops. After reset the output is zero while reset is held. The output then carries stale array contents for `DEPTH` cycles until the first fresh word arrives. Downstream logic is expected to ignore this fill interval. The delay is set when the block is built and cannot be changed while it runs. `DEPTH` must be a power of two.

Top module: `mem_delay_line`

## Requirements
- R1: A word sampled on `din` at a rising clock edge appears on `dout` exactly `DEPTH` rising edges later, with all `WIDTH` bits intact, for every edge at least `DEPTH` edges after reset was released.
- R2: The delay holds for streams many times longer than `DEPTH`. A stream of distinct values shows no aliasing or reordering when the addresses wrap from the last entry back to entry zero.
- R3: A clock edge with `rst` high sets the read address to entry zero and the write address to the last entry (all ones). The first word presented after reset release is therefore the first fresh word seen on `dout`, `DEPTH` edges later.
- R4: Outside reset, both addresses advance by one on every clock edge, modulo `DEPTH`. The write address always equals the read address minus one, modulo `DEPTH`.
- R5: In any cycle outside reset, the read and write addresses differ, so no location is read and written in the same cycle.
- R6: `dout` is zero after every clock edge that samples `rst` high. This includes a reset asserted in the middle of a running stream.
- R7: The delay is independent of the data pattern. All-zero words, all-one words and alternating-bit words each come out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock |
| rst  | input  | 1 | Synchronous active-high reset |
| din  | input  | WIDTH | Word entering the delay line, sampled every cycle |
| dout | output | WIDTH | Registered word leaving the delay line, `DEPTH` cycles late |

## Verification
The bench builds two instances from the same stimulus. One uses `DEPTH=16` and `WIDTH=12`, so several hundred cycles wrap the addresses many times and a counting stream can expose aliasing. The other uses the smallest legal `DEPTH=2` with `WIDTH=4`. At that depth the write address lies directly behind the read address and wraps every other cycle, which is the tightest case for the one-behind offset and for the read/write separation. A reset in the middle of the stream checks that both instances refill and resume the exact delay.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Address width for an array of the given depth (minimum one bit).
  function automatic int unsigned ptr_bits(int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/dly_ptr.sv
// Free-running address counter with a reset value chosen by the parent.
module dly_ptr #(
  parameter int unsigned  AW   = 4,
  parameter bit [AW-1:0]  INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= INIT;
    end else begin
      addr <= addr + 1'b1;  // wraps modulo 2**AW
    end
  end

endmodule

// File: rtl/dly_ram.sv
// Simple dual-port array: one write port, one registered read port.
// No reset on the array or read register so block RAM can be inferred.
module dly_ram #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = dly_pkg::ptr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    mem[waddr] <= wdata;
    rdata      <= mem[raddr];
  end

endmodule

// File: rtl/mem_delay_line.sv
// Fixed delay of DEPTH cycles built from a dual-port array and two counters.
module mem_delay_line #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned AW = dly_pkg::ptr_bits(DEPTH);

  initial begin
    assert (DEPTH >= 2 && DEPTH == (1 << AW))
      else $error("mem_delay_line: DEPTH must be a power of two, at least 2");
  end

  logic [AW-1:0]    rd_addr;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] ram_q;
  logic [WIDTH-1:0] dout_q;

  // Read starts at the first entry; write starts one lap behind at the last.
  dly_ptr #(.AW(AW), .INIT('0)) u_rd_ptr (
    .clk  (clk),
    .rst  (rst),
    .addr (rd_addr)
  );

  dly_ptr #(.AW(AW), .INIT('1)) u_wr_ptr (
    .clk  (clk),
    .rst  (rst),
    .addr (wr_addr)
  );

  dly_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .waddr (wr_addr),
    .wdata (din),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  // Output register: array read (DEPTH-1 edges) plus this stage = DEPTH edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
    end else begin
      dout_q <= ram_q;
    end
  end

  assign dout = dout_q;

  // R3: reset places the counters at the first and last entries.
  assert_reset_ptrs_R3: assert property (@(posedge clk)
    rst |=> (rd_addr == '0 && wr_addr == '1));

  // R4: the write address stays exactly one behind the read address.
  assert_gap_R4: assert property (@(posedge clk) disable iff (rst)
    AW'(wr_addr + 1'b1) == rd_addr);

  // R4: the read address advances by one per cycle outside reset.
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_addr == AW'($past(rd_addr) + 1'b1));

  // R5: no cycle reads and writes the same location.
  assert_no_collide_R5: assert property (@(posedge clk) disable iff (rst)
    rd_addr != wr_addr);

  // R6: output cleared after any edge that samples reset.
  assert_dout_reset_R6: assert property (@(posedge clk)
    rst |=> dout == '0);

endmodule

// File: tb/tb_mem_delay_line.sv
module tb_mem_delay_line;

  localparam int unsigned BIG_W = 12;
  localparam int unsigned BIG_D = 16;
  localparam int unsigned MIN_W = 4;
  localparam int unsigned MIN_D = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [BIG_W-1:0] din = '0;
  logic [BIG_W-1:0] dout_big;
  logic [MIN_W-1:0] dout_min;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string tag    = "R3";

  logic [BIG_W-1:0] q_big [$];
  logic [BIG_W-1:0] q_min [$];

  always #2 clk = ~clk;  // 250 MHz

  mem_delay_line #(.WIDTH(BIG_W), .DEPTH(BIG_D)) dut (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (dout_big)
  );

  mem_delay_line #(.WIDTH(MIN_W), .DEPTH(MIN_D)) dut_min (
    .clk  (clk),
    .rst  (rst),
    .din  (din[MIN_W-1:0]),
    .dout (dout_min)
  );

  // Driver: present one word for the next edge and record it as expected.
  task automatic drive_word(input logic [BIG_W-1:0] v);
    @(negedge clk);
    rst = 1'b0;
    din = v;
    q_big.push_back(v);
    q_min.push_back(v);
  endtask

  task automatic hold_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1'b1;
      din = BIG_W'($urandom);
      q_big.delete();
      q_min.delete();
    end
  endtask

  // Monitor: after each edge, compare outputs with the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        checks++;  // R6
        if (dout_big != '0 || dout_min != '0) begin
          errors++;
          $display("FAIL R6: dout big=%h min=%h expected 0", dout_big, dout_min);
        end
      end else begin
        if (q_big.size() > BIG_D) begin
          logic [BIG_W-1:0] e;
          e = q_big.pop_front();
          checks++;  // R1 delay of DEPTH, plus the phase tag
          if (dout_big != e) begin
            errors++;
            $display("FAIL R1 %s (depth %0d): actual %h expected %h", tag, BIG_D, dout_big, e);
          end
        end
        if (q_min.size() > MIN_D) begin
          logic [BIG_W-1:0] e;
          e = q_min.pop_front();
          checks++;  // R1 at the minimum depth, R4 R5 tightest wrap
          if (dout_min != e[MIN_W-1:0]) begin
            errors++;
            $display("FAIL R1 %s (depth %0d): actual %h expected %h", tag, MIN_D, dout_min, e[MIN_W-1:0]);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    hold_reset(4);

    // R3: first words after reset, counting pattern
    tag = "R3";
    for (int i = 0; i < 100; i++) drive_word(BIG_W'(i + 1));

    // R2 R4: long stream across many wraps, distinct then random values
    tag = "R2 R4";
    for (int i = 0; i < 150; i++) drive_word(BIG_W'(12'h100 + i));
    for (int i = 0; i < 100; i++) drive_word(BIG_W'($urandom));

    // R7 R5: pattern independence
    tag = "R7 R5";
    for (int i = 0; i < 20; i++) drive_word('0);
    for (int i = 0; i < 20; i++) drive_word('1);
    for (int i = 0; i < 40; i++) drive_word((i % 2 == 0) ? 12'h555 : 12'hAAA);

    // R6: reset in the middle of a running stream
    tag = "R6";
    hold_reset(3);

    // R3: refill after mid-stream reset
    tag = "R3";
    for (int i = 0; i < 60; i++) drive_word(BIG_W'(12'hC00 + i * 3));
    for (int i = 0; i < 20; i++) drive_word(BIG_W'(12'h7E0 + i));

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule